// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block steps one DMA channel through a programmed transfer. A load strobe captures the page byte, a 16-bit base address, a 16-bit base count and the autoinitialize flag. It copies the base values into the current address and current count registers and unmasks the channel. After that, each step strobe stands for one completed bus transfer. On each accepted step the current address goes up by one and the current count goes down by one. The count is programmed as the number of transfers minus one.

A build-time parameter chooses between a byte channel and a word channel. A byte channel places the page byte directly above the 16-bit address. A word channel counts in 16-bit words: it drops page bit 0, shifts the address up by one and forces byte-address bit 0 low. A byte page therefore covers 64K bytes and a word page covers 128K bytes. The 16-bit address wraps inside its page and never carries into the page bits.

Terminal count is flagged in the same cycle as the step that takes the count from zero to all ones. With autoinitialize set, the channel then reloads from its base values and stays live. Without it, the channel masks itself and ignores steps until it is loaded again. A residue is always available: one value in transfer units and one value in bytes.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the current address and current count are 0, masked is 1, termCount is 0, residue is 1 and physAddr is 0.
- R2: A cycle with loadIn high captures pageIn, baseAddrIn, baseCountIn and autoInitIn. From the next cycle curAddr equals baseAddrIn, curCount equals baseCountIn and masked is 0. A step in the same cycle as a load is ignored.
- R3: With WORD_MODE=0, physAddr[23:16] is the page byte and physAddr[15:0] is curAddr.
- R4: With WORD_MODE=1, physAddr[23:17] is page bits 7:1, physAddr[16:1] is curAddr and physAddr[0] is 0. Page bit 0 has no effect on physAddr.
- R5: A step taken while masked is 0 and loadIn is 0, and not at terminal count, makes curAddr one higher (mod 2^16) and curCount one lower in the next cycle.
- R6: When curAddr wraps from 0xFFFF to 0x0000, the page bits of physAddr do not change.
- R7: termCount is high, combinationally, only in a cycle with an accepted step while curCount is 0. With a programmed count of N-1, the N-th step is the first one that raises it.
- R8: With autoinitialize set, the step that raises termCount reloads curAddr and curCount from the base values, and masked stays 0.
- R9: Without autoinitialize, masked becomes 1 after the terminal step, with curAddr advanced by one and curCount at 0xFFFF. Later steps change nothing until the next load.
- R10: residue equals curCount+1 mod 2^16. It is therefore 0 after a complete transfer without autoinitialize.
- R11: residueBytes (17 bits) equals residue with WORD_MODE=0 and residue*2 with WORD_MODE=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadIn | input | 1 | Program strobe for page, base values and autoinitialize flag |
| pageIn | input | 8 | Page byte (bits 23:16, or 23:17 on a word channel) |
| baseAddrIn | input | 16 | Start address in transfer units |
| baseCountIn | input | 16 | Transfer count minus one |
| autoInitIn | input | 1 | Reload at terminal count instead of masking |
| stepIn | input | 1 | One transfer completed |
| physAddr | output | 24 | Physical byte address of the current transfer |
| curAddr | output | 16 | Current address register |
| curCount | output | 16 | Current count register |
| termCount | output | 1 | Accepted step is the last of the block |
| masked | output | 1 | Channel ignores steps |
| residue | output | 16 | Transfers left, mod 2^16 |
| residueBytes | output | 17 | Bytes left |

## Verification
The bench runs a byte channel and a word channel side by side. It sweeps many short counts, both with and without autoinitialize. It checks that terminal count falls on exactly the N-th step: an off-by-one count compare would flag a step early or late, and a design that reloads one step off would drift its reload point. An address wrap with an odd page byte exposes a carry into the page and any weight given to page bit 0 on the word channel. A full 65536-transfer block shows that 0xFFFF means the largest count and not zero. Extra steps after masking and a load that coincides with a step show whether the design wrongly advances when it should hold.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  // Strobes from the sequencing control to the register datapath.
  typedef struct packed {
    logic load;     // capture programming, copy base into current
    logic advance;  // address +1, count -1
    logic reload;   // copy base into current at terminal count
  } seqCtl_t;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIn,
  input  logic             stepIn,
  input  logic             autoInitIn,
  input  logic [CNT_W-1:0] curCount,
  output seqCtl_t          ctl,
  output logic             termCount,
  output logic             masked
);
  logic autoInitQ;
  logic accept;
  logic lastStep;

  assign accept    = stepIn & ~masked & ~loadIn;
  assign lastStep  = (curCount == '0);
  assign termCount = accept & lastStep;

  always_comb begin
    ctl.load    = loadIn;
    ctl.reload  = termCount & autoInitQ;
    ctl.advance = accept & ~(termCount & autoInitQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masked    <= 1'b1;
      autoInitQ <= 1'b0;
    end else if (loadIn) begin
      masked    <= 1'b0;
      autoInitQ <= autoInitIn;
    end else if (termCount && !autoInitQ) begin
      masked    <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 16,
  localparam int PHYS_W   = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [ADDR_W-1:0] baseAddrIn,
  input  logic [ADDR_W-1:0] baseCountIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic [ADDR_W-1:0] baseAddrQ,
  output logic [ADDR_W-1:0] baseCountQ,
  output logic [PHYS_W-1:0] physAddr,
  output logic [ADDR_W-1:0] residue,
  output logic [ADDR_W:0]   residueBytes
);
  logic [PAGE_W-1:0] pageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ      <= '0;
      baseAddrQ  <= '0;
      baseCountQ <= '0;
      curAddr    <= '0;
      curCount   <= '0;
    end else if (ctl.load) begin
      pageQ      <= pageIn;
      baseAddrQ  <= baseAddrIn;
      baseCountQ <= baseCountIn;
      curAddr    <= baseAddrIn;
      curCount   <= baseCountIn;
    end else if (ctl.reload) begin
      curAddr    <= baseAddrQ;
      curCount   <= baseCountQ;
    end else if (ctl.advance) begin
      curAddr    <= curAddr + ADDR_W'(1);   // wraps inside the page
      curCount   <= curCount - ADDR_W'(1);
    end
  end

  assign residue = curCount + ADDR_W'(1);

  generate
    if (WORD_MODE) begin : gWord
      // Page bit 0 carries no weight; address shifted up one byte lane.
      assign physAddr     = {pageQ[PAGE_W-1:1], curAddr, pageQ[0] & 1'b0};
      assign residueBytes = {residue, 1'b0};
    end else begin : gByte
      assign physAddr     = {pageQ, curAddr};
      assign residueBytes = {1'b0, residue};
    end
  endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 16,
  localparam int PHYS_W   = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadIn,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [ADDR_W-1:0] baseAddrIn,
  input  logic [ADDR_W-1:0] baseCountIn,
  input  logic              autoInitIn,
  input  logic              stepIn,
  output logic [PHYS_W-1:0] physAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic              termCount,
  output logic              masked,
  output logic [ADDR_W-1:0] residue,
  output logic [ADDR_W:0]   residueBytes
);
  seqCtl_t           ctl;
  logic [ADDR_W-1:0] baseAddrQ;
  logic [ADDR_W-1:0] baseCountQ;

  dma_seq_ctrl #(.CNT_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .stepIn(stepIn),
    .autoInitIn(autoInitIn), .curCount(curCount), .ctl(ctl),
    .termCount(termCount), .masked(masked)
  );

  dma_seq_dpath #(.WORD_MODE(WORD_MODE), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pageIn(pageIn),
    .baseAddrIn(baseAddrIn), .baseCountIn(baseCountIn),
    .curAddr(curAddr), .curCount(curCount),
    .baseAddrQ(baseAddrQ), .baseCountQ(baseCountQ),
    .physAddr(physAddr), .residue(residue), .residueBytes(residueBytes)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter bit WORD_MODE = 1'b0,
  parameter int PAGE_W    = 8,
  parameter int ADDR_W    = 16,
  localparam int PHYS_W   = PAGE_W + ADDR_W,
  localparam int PLO      = ADDR_W + (WORD_MODE ? 1 : 0)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadIn,
  input logic              stepIn,
  input logic [ADDR_W-1:0] baseAddrIn,
  input logic [ADDR_W-1:0] baseCountIn,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] curCount,
  input logic [ADDR_W-1:0] baseAddrQ,
  input logic [ADDR_W-1:0] baseCountQ,
  input logic              termCount,
  input logic              masked,
  input logic [PHYS_W-1:0] physAddr
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    loadIn |=> (!masked && curAddr == $past(baseAddrIn) && curCount == $past(baseCountIn))); // R2

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (stepIn && !masked && !loadIn && !termCount) |=>
      (curAddr == $past(curAddr) + ADDR_W'(1) && curCount == $past(curCount) - ADDR_W'(1))); // R5

  AST_NO_PAGE_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (stepIn && !masked && !loadIn && !termCount) |=>
      physAddr[PHYS_W-1:PLO] == $past(physAddr[PHYS_W-1:PLO])); // R6

  AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> (curCount == '0 && stepIn && !masked && !loadIn)); // R7

  AST_TC_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    termCount |=> (masked || (curAddr == $past(baseAddrQ) && curCount == $past(baseCountQ)))); // R8

  AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (masked && !loadIn) |=> (masked && $stable(curAddr) && $stable(curCount))); // R9
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.WORD_MODE(WORD_MODE), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .loadIn(loadIn), .stepIn(stepIn),
  .baseAddrIn(baseAddrIn), .baseCountIn(baseCountIn),
  .curAddr(curAddr), .curCount(curCount),
  .baseAddrQ(baseAddrQ), .baseCountQ(baseCountQ),
  .termCount(termCount), .masked(masked), .physAddr(physAddr)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadIn = 1'b0;
  logic [7:0]  pageIn = '0;
  logic [15:0] baseAddrIn = '0;
  logic [15:0] baseCountIn = '0;
  logic        autoInitIn = 1'b0;
  logic        stepIn = 1'b0;

  logic [23:0] physB, physW;
  logic [15:0] addrB, addrW, cntB, cntW, resB, resW;
  logic        tcB, tcW, mskB, mskW;
  logic [16:0] rbB, rbW;

  always #5 clk = ~clk;

  dma_chan_seq #(.WORD_MODE(1'b0)) dut (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .pageIn(pageIn),
    .baseAddrIn(baseAddrIn), .baseCountIn(baseCountIn), .autoInitIn(autoInitIn),
    .stepIn(stepIn), .physAddr(physB), .curAddr(addrB), .curCount(cntB),
    .termCount(tcB), .masked(mskB), .residue(resB), .residueBytes(rbB)
  );

  dma_chan_seq #(.WORD_MODE(1'b1)) dutW (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .pageIn(pageIn),
    .baseAddrIn(baseAddrIn), .baseCountIn(baseCountIn), .autoInitIn(autoInitIn),
    .stepIn(stepIn), .physAddr(physW), .curAddr(addrW), .curCount(cntW),
    .termCount(tcW), .masked(mskW), .residue(resW), .residueBytes(rbW)
  );

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  mPage = '0;
  logic [15:0] mAddr = '0, mCnt = '0, mBaseA = '0, mBaseC = '0;
  bit          mMask = 1'b1, mAuto = 1'b0;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    logic [15:0] r;
    r = mCnt + 16'd1;
    chkEq({tag, " R5 addr"}, {16'd0, addrB}, {16'd0, mAddr});
    chkEq({tag, " R5 count"}, {16'd0, cntB}, {16'd0, mCnt});
    chkEq({tag, " R9 mask"}, {31'd0, mskB}, {31'd0, mMask});
    chkEq({tag, " word state"}, {addrW, cntW}, {mAddr, mCnt});
    chkEq({tag, " R3 phys"}, {8'd0, physB}, {8'd0, mPage, mAddr});
    chkEq({tag, " R4 phys"}, {8'd0, physW}, {8'd0, mPage[7:1], mAddr, 1'b0});
    chkEq({tag, " R10 residue"}, {resB, resW}, {r, r});
    chkEq({tag, " R11 bytes byte"}, {15'd0, rbB}, {15'd0, 1'b0, r});
    chkEq({tag, " R11 bytes word"}, {15'd0, rbW}, {15'd0, r, 1'b0});
  endtask

  task automatic doLoad(input logic [7:0] pg, input logic [15:0] a, input logic [15:0] c,
                        input bit au, input bit withStep);
    @(negedge clk);
    pageIn = pg; baseAddrIn = a; baseCountIn = c; autoInitIn = au;
    loadIn = 1'b1; stepIn = withStep;
    #1 chkEq("R2 no tc on load", {30'd0, tcB, tcW}, 32'd0);
    @(negedge clk);
    loadIn = 1'b0; stepIn = 1'b0;
    mPage = pg; mAddr = a; mCnt = c; mBaseA = a; mBaseC = c; mAuto = au; mMask = 1'b0;
    checkState("R2 load");
  endtask

  task automatic doStep(input bit full);
    bit acc, tc;
    acc = !mMask;
    tc  = acc && (mCnt == 16'd0);
    @(negedge clk);
    stepIn = 1'b1;
    #1 chkEq("R7 termCount", {30'd0, tcB, tcW}, {30'd0, tc, tc});
    @(negedge clk);
    stepIn = 1'b0;
    if (acc) begin
      if (tc && mAuto) begin
        mAddr = mBaseA; mCnt = mBaseC;
      end else begin
        mAddr = mAddr + 16'd1; mCnt = mCnt - 16'd1;
      end
      if (tc && !mAuto) mMask = 1'b1;
    end
    if (full) checkState(tc ? "R8/R9 tc step" : "step");
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    chkEq("R1 addr/count", {addrB, cntB}, 32'd0);
    chkEq("R1 masked", {30'd0, mskB, mskW}, 32'd3);
    chkEq("R1 residue", {resB, resW}, {16'd1, 16'd1});
    chkEq("R1 phys", {8'd0, physB}, 32'd0);
    chkEq("R1 termCount", {30'd0, tcB, tcW}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R9 steps before any load are ignored
    doStep(1'b1);

    // R7/R9 sweep of short counts, no autoinitialize
    for (int n = 1; n <= 12; n++) begin
      doLoad(8'h5A + 8'(n), 16'h1230 + 16'(n * 7), 16'(n - 1), 1'b0, 1'b0);
      for (int k = 0; k < n; k++) doStep(1'b1);
      chkEq("R9 masked after tc", {31'd0, mskB}, 32'd1);
      chkEq("R10 residue zero after block", {16'd0, resB}, 32'd0);
      doStep(1'b1);   // R9 ignored
      doStep(1'b1);
    end

    // R8 autoinitialize sweep
    for (int n = 1; n <= 6; n++) begin
      doLoad(8'hC3, 16'h8000 - 16'(n), 16'(n - 1), 1'b1, 1'b0);
      for (int k = 0; k < 3 * n; k++) doStep(1'b1);
      chkEq("R8 still unmasked", {30'd0, mskB, mskW}, 32'd0);
      chkEq("R8 reloaded addr", {16'd0, addrB}, {16'd0, 16'h8000 - 16'(n)});
    end

    // R6 address wrap with odd page, R4 page bit 0 weightless
    doLoad(8'h37, 16'hFFFE, 16'd3, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) doStep(1'b1);
    chkEq("R6 wrapped addr", {16'd0, addrB}, 32'h0002);
    chkEq("R6 page kept byte", {24'd0, physB[23:16]}, 32'h37);
    chkEq("R4 page bit0 dropped", {25'd0, physW[23:17]}, {25'd0, 7'h1B});
    doLoad(8'h36, 16'h0040, 16'd1, 1'b0, 1'b0);
    chkEq("R4 same word phys for page 36", {8'd0, physW}, {8'd0, 7'h1B, 16'h0040, 1'b0});

    // R2 load wins over a simultaneous step
    doLoad(8'h11, 16'h2222, 16'h0005, 1'b0, 1'b1);
    chkEq("R2 step ignored on load", {addrB, cntB}, {16'h2222, 16'h0005});

    // R7 full 65536-transfer block on 0xFFFF
    doLoad(8'h02, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
    chkEq("R11 full block bytes word", {15'd0, rbW}, 32'd0);
    doStep(1'b1);
    chkEq("R11 word bytes after 1", {15'd0, rbW}, 32'h1FFFE);
    for (int k = 1; k < 65535; k++) doStep(1'b0);
    checkState("R7 one left");
    chkEq("R7 last count", {16'd0, cntB}, 32'd0);
    doStep(1'b1);
    chkEq("R9 full block masked", {31'd0, mskB}, 32'd1);
    chkEq("R10 full block residue", {16'd0, resB}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule